// File: doc/BRIEF.md
# Strap capture and frequency code source selector

This block sits in front of a clock synthesizer. It captures the board's configuration pins while the power-good strobe says they are valid. The pins are a five-bit frequency code, two drive-strength bits and two output-frequency select bits. Once the strobe has come and gone, the captured values are frozen until the next reset.

The block then decides where the five-bit frequency code that drives the synthesizer comes from. There are three sources: the captured pins, a code that software writes over the serial bus, and a watchdog reload that overrides both. It also holds the divider-programming enable and the M and N values. It returns the captured pin values for readback.

After the power-on period the two output-frequency select bits become ordinary software-writable bits. Whenever the active code changes, the block raises a one-cycle pulse so the synthesizer can retune.

Top module: `strap_freq_select`

## Requirements
- R1: After reset the block holds these values: `active_code`=0, `fs_readback`=0, `drv_readback`=0, `osel`=0, `sw_sel_en`=0, `sw_code`=0, `mn_active`=0, `m_div`=5'b01101, `n_div`=9'h167, `code_update`=0 and `strap_frozen`=0.
- R2: In every cycle in which `pwrgd_n` is low and the latch is not frozen, `pin_fs` and `pin_drv` are sampled. They appear on `fs_readback` and `drv_readback` after the next clock edge.
- R3: Once `pwrgd_n` has been low and then returns high, `strap_frozen` rises one edge later. From then on, pin changes and further strobe pulses leave the captured values unchanged until the next reset. After a reset the pins are captured again.
- R4: Before the freeze, `osel` follows `pin_osel` whenever the pins are sampled, and writes through `osel_we` are ignored. After the freeze, a write loads `osel_wdata` and the pins are ignored. In `osel`, bit 0 selects 24 MHz (0) or 48 MHz (1), and bit 1 selects 48 MHz (0) or 66 MHz (1).
- R5: When `sw_sel_en` is 0, `active_code` equals the captured pin code. When it is 1, `active_code` equals `sw_code`. A write through `sel_we` loads both values on the next edge.
- R6: `fs_readback` always shows the captured pin code, whichever source is active.
- R7: A `wd_reload` with `wd_use_safe`=1 loads `wd_safe_code` into `sw_code` and sets `sw_sel_en`, so `active_code` equals the safe code after that edge.
- R8: A `wd_reload` with `wd_use_safe`=0 clears `sw_sel_en` and copies the captured pin code into `sw_code`, so `active_code` returns to the pin code.
- R9: A `wd_reload` clears `mn_active`. In the same cycle it takes priority over any write through `sel_we` or `mn_we`, and those writes are dropped entirely. That includes M and N.
- R10: A write through `mn_we` loads `mn_active`, `m_div` and `n_div` on the next edge.
- R11: `code_update` is high for exactly the one cycle following each edge at which `active_code` changes, and low otherwise.
- R12: `drv_readback` holds the captured drive-strength pins under the same sampling and freezing rules as the frequency code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwrgd_n | input | 1 | Active-low power-good strobe qualifying the pins |
| pin_fs | input | 5 | Frequency-code configuration pins |
| pin_drv | input | 2 | Drive-strength configuration pins |
| pin_osel | input | 2 | Output-frequency select pins |
| osel_we | input | 1 | Write strobe for the output-frequency select bits |
| osel_wdata | input | 2 | Write data for the output-frequency select bits |
| sel_we | input | 1 | Write strobe for the software source enable and code |
| sel_en_wdata | input | 1 | Write data for the software source enable |
| sel_code_wdata | input | 5 | Write data for the software code |
| mn_we | input | 1 | Write strobe for the divider programming fields |
| mn_en_wdata | input | 1 | Write data for the divider programming enable |
| m_wdata | input | 5 | Write data for M |
| n_wdata | input | 9 | Write data for N |
| wd_reload | input | 1 | Watchdog reload request, one cycle |
| wd_use_safe | input | 1 | Reload picks the safe code (1) or the pin code (0) |
| wd_safe_code | input | 5 | Safe code used by a reload |
| active_code | output | 5 | Frequency code driving the synthesizer |
| code_update | output | 1 | One-cycle pulse after the active code changes |
| sw_sel_en | output | 1 | Software source enable |
| sw_code | output | 5 | Software frequency code |
| mn_active | output | 1 | Direct M/N programming enabled |
| m_div | output | 5 | M divider value |
| n_div | output | 9 | N divider value |
| fs_readback | output | 5 | Captured frequency-code pins |
| drv_readback | output | 2 | Captured drive-strength pins |
| osel | output | 2 | Output-frequency select bits |
| strap_frozen | output | 1 | Capture window has closed |

## Verification
The hardest situation to reach is a watchdog reload that lands in the same cycle as software writes, after the latch has frozen. Reaching it needs a full strobe sequence and a software takeover first. The stimulus uses directed steps to close the capture window and to place a reload on top of selector and divider writes. It then runs a long random phase that issues reloads, safe or pin flavoured, and writes at independent rates, so collisions happen many times. A second reset with new pins shows that the frozen latch opens again.

// File: rtl/strap_sel_pkg.sv
package strap_sel_pkg;
  parameter int FS_W   = 5;
  parameter int DRV_W  = 2;
  parameter int OSEL_W = 2;
  parameter int M_W    = 5;
  parameter int N_W    = 9;

  parameter logic [M_W-1:0] M_RST = 5'b01101;
  parameter logic [N_W-1:0] N_RST = 9'h167;

  // Capture window: waiting for the strobe, strobe seen, closed.
  typedef enum logic [1:0] {
    CAP_WAIT   = 2'd0,
    CAP_ARMED  = 2'd1,
    CAP_FROZEN = 2'd2
  } cap_state_t;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import strap_sel_pkg::*;
#(
  parameter int FS_W   = strap_sel_pkg::FS_W,
  parameter int DRV_W  = strap_sel_pkg::DRV_W,
  parameter int OSEL_W = strap_sel_pkg::OSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrgd_n,
  input  logic [FS_W-1:0]   pin_fs,
  input  logic [DRV_W-1:0]  pin_drv,
  input  logic [OSEL_W-1:0] pin_osel,
  input  logic              osel_we,
  input  logic [OSEL_W-1:0] osel_wdata,
  output logic [FS_W-1:0]   fs_lat,
  output logic [DRV_W-1:0]  drv_lat,
  output logic [OSEL_W-1:0] osel,
  output logic              frozen
);
  cap_state_t        state_q, state_d;
  logic [FS_W-1:0]   fs_q, fs_d;
  logic [DRV_W-1:0]  drv_q, drv_d;
  logic [OSEL_W-1:0] osel_q, osel_d;
  logic              sample;
  logic              sw_owns;

  assign sample  = (state_q != CAP_FROZEN) && !pwrgd_n;
  assign sw_owns = (state_q == CAP_FROZEN) && osel_we;

  always_comb begin
    state_d = state_q;
    case (state_q)
      CAP_WAIT:  if (!pwrgd_n) state_d = CAP_ARMED;
      CAP_ARMED: if (pwrgd_n)  state_d = CAP_FROZEN;
      default:   state_d = CAP_FROZEN;
    endcase
  end

  always_comb begin
    fs_d  = fs_q;
    drv_d = drv_q;
    if (sample) begin
      fs_d  = pin_fs;
      drv_d = pin_drv;
    end
  end

  // Each select bit is pin-owned during power-on, software-owned after.
  for (genvar b = 0; b < OSEL_W; b++) begin : g_osel
    always_comb begin
      osel_d[b] = osel_q[b];
      if (sample)       osel_d[b] = pin_osel[b];
      else if (sw_owns) osel_d[b] = osel_wdata[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAP_WAIT;
      fs_q    <= '0;
      drv_q   <= '0;
      osel_q  <= '0;
    end else begin
      state_q <= state_d;
      fs_q    <= fs_d;
      drv_q   <= drv_d;
      osel_q  <= osel_d;
    end
  end

  assign fs_lat  = fs_q;
  assign drv_lat = drv_q;
  assign osel    = osel_q;
  assign frozen  = (state_q == CAP_FROZEN);
endmodule

// File: rtl/code_source.sv
module code_source #(
  parameter int FS_W = strap_sel_pkg::FS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FS_W-1:0] fs_lat,
  input  logic            sel_we,
  input  logic            sel_en_wdata,
  input  logic [FS_W-1:0] sel_code_wdata,
  input  logic            wd_reload,
  input  logic            wd_use_safe,
  input  logic [FS_W-1:0] wd_safe_code,
  output logic            sw_en,
  output logic [FS_W-1:0] sw_code,
  output logic [FS_W-1:0] active_code,
  output logic            code_update
);
  logic            en_q, en_d;
  logic [FS_W-1:0] code_q, code_d;
  logic [FS_W-1:0] prev_q;
  logic [FS_W-1:0] active;

  always_comb begin
    en_d   = en_q;
    code_d = code_q;
    if (wd_reload) begin
      en_d   = wd_use_safe;
      code_d = wd_use_safe ? wd_safe_code : fs_lat;
    end else if (sel_we) begin
      en_d   = sel_en_wdata;
      code_d = sel_code_wdata;
    end
  end

  assign active = en_q ? code_q : fs_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      code_q <= '0;
      prev_q <= '0;
    end else begin
      en_q   <= en_d;
      code_q <= code_d;
      prev_q <= active;
    end
  end

  assign sw_en       = en_q;
  assign sw_code     = code_q;
  assign active_code = active;
  assign code_update = (active != prev_q);
endmodule

// File: rtl/mn_config.sv
module mn_config #(
  parameter int             M_W   = strap_sel_pkg::M_W,
  parameter int             N_W   = strap_sel_pkg::N_W,
  parameter logic [M_W-1:0] M_RST = strap_sel_pkg::M_RST,
  parameter logic [N_W-1:0] N_RST = strap_sel_pkg::N_RST
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mn_we,
  input  logic           mn_en_wdata,
  input  logic [M_W-1:0] m_wdata,
  input  logic [N_W-1:0] n_wdata,
  input  logic           wd_reload,
  output logic           mn_en,
  output logic [M_W-1:0] m_div,
  output logic [N_W-1:0] n_div
);
  logic           en_q, en_d;
  logic [M_W-1:0] m_q, m_d;
  logic [N_W-1:0] n_q, n_d;
  logic           wr_ok;

  assign wr_ok = mn_we && !wd_reload;

  always_comb begin
    en_d = en_q;
    m_d  = m_q;
    n_d  = n_q;
    if (wd_reload) begin
      en_d = 1'b0;
    end else if (wr_ok) begin
      en_d = mn_en_wdata;
      m_d  = m_wdata;
      n_d  = n_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      m_q  <= M_RST;
      n_q  <= N_RST;
    end else begin
      en_q <= en_d;
      m_q  <= m_d;
      n_q  <= n_d;
    end
  end

  assign mn_en = en_q;
  assign m_div = m_q;
  assign n_div = n_q;
endmodule

// File: rtl/strap_freq_select.sv
module strap_freq_select #(
  parameter int FS_W        = strap_sel_pkg::FS_W,
  parameter int DRV_W       = strap_sel_pkg::DRV_W,
  parameter int OSEL_W      = strap_sel_pkg::OSEL_W,
  parameter int M_W         = strap_sel_pkg::M_W,
  parameter int N_W         = strap_sel_pkg::N_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrgd_n,
  input  logic [FS_W-1:0]   pin_fs,
  input  logic [DRV_W-1:0]  pin_drv,
  input  logic [OSEL_W-1:0] pin_osel,
  input  logic              osel_we,
  input  logic [OSEL_W-1:0] osel_wdata,
  input  logic              sel_we,
  input  logic              sel_en_wdata,
  input  logic [FS_W-1:0]   sel_code_wdata,
  input  logic              mn_we,
  input  logic              mn_en_wdata,
  input  logic [M_W-1:0]    m_wdata,
  input  logic [N_W-1:0]    n_wdata,
  input  logic              wd_reload,
  input  logic              wd_use_safe,
  input  logic [FS_W-1:0]   wd_safe_code,
  output logic [FS_W-1:0]   active_code,
  output logic              code_update,
  output logic              sw_sel_en,
  output logic [FS_W-1:0]   sw_code,
  output logic              mn_active,
  output logic [M_W-1:0]    m_div,
  output logic [N_W-1:0]    n_div,
  output logic [FS_W-1:0]   fs_readback,
  output logic [DRV_W-1:0]  drv_readback,
  output logic [OSEL_W-1:0] osel,
  output logic              strap_frozen
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] rst_pipe;
  logic              rst_sync_n;
  logic [FS_W-1:0]   fs_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_MSB-1:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_MSB];

  strap_capture #(.FS_W(FS_W), .DRV_W(DRV_W), .OSEL_W(OSEL_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pwrgd_n    (pwrgd_n),
    .pin_fs     (pin_fs),
    .pin_drv    (pin_drv),
    .pin_osel   (pin_osel),
    .osel_we    (osel_we),
    .osel_wdata (osel_wdata),
    .fs_lat     (fs_lat),
    .drv_lat    (drv_readback),
    .osel       (osel),
    .frozen     (strap_frozen)
  );

  code_source #(.FS_W(FS_W)) u_src (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .fs_lat         (fs_lat),
    .sel_we         (sel_we),
    .sel_en_wdata   (sel_en_wdata),
    .sel_code_wdata (sel_code_wdata),
    .wd_reload      (wd_reload),
    .wd_use_safe    (wd_use_safe),
    .wd_safe_code   (wd_safe_code),
    .sw_en          (sw_sel_en),
    .sw_code        (sw_code),
    .active_code    (active_code),
    .code_update    (code_update)
  );

  mn_config #(.M_W(M_W), .N_W(N_W)) u_mn (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .mn_we       (mn_we),
    .mn_en_wdata (mn_en_wdata),
    .m_wdata     (m_wdata),
    .n_wdata     (n_wdata),
    .wd_reload   (wd_reload),
    .mn_en       (mn_active),
    .m_div       (m_div),
    .n_div       (n_div)
  );

  assign fs_readback = fs_lat;
endmodule

// File: rtl/strap_freq_select_chk.sv
module strap_freq_select_chk #(
  parameter int FS_W   = strap_sel_pkg::FS_W,
  parameter int DRV_W  = strap_sel_pkg::DRV_W,
  parameter int OSEL_W = strap_sel_pkg::OSEL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwrgd_n,
  input logic [OSEL_W-1:0] pin_osel,
  input logic              wd_reload,
  input logic              wd_use_safe,
  input logic [FS_W-1:0]   wd_safe_code,
  input logic [FS_W-1:0]   active_code,
  input logic              code_update,
  input logic              sw_sel_en,
  input logic              mn_active,
  input logic [FS_W-1:0]   fs_readback,
  input logic [DRV_W-1:0]  drv_readback,
  input logic [OSEL_W-1:0] osel,
  input logic              strap_frozen
);
  p_frozen_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strap_frozen |=> strap_frozen && $stable(fs_readback) && $stable(drv_readback));

  p_osel_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strap_frozen && !pwrgd_n) |=> osel == $past(pin_osel));

  p_hw_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_sel_en |-> active_code == fs_readback);

  p_safe_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_reload && wd_use_safe) |=> sw_sel_en && active_code == $past(wd_safe_code));

  p_pin_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_reload && !wd_use_safe) |=> !sw_sel_en && active_code == fs_readback);

  p_reload_mn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reload |=> !mn_active);

  p_update_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_code) |-> code_update);
endmodule

bind strap_freq_select strap_freq_select_chk #(
  .FS_W(FS_W), .DRV_W(DRV_W), .OSEL_W(OSEL_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .pwrgd_n      (pwrgd_n),
  .pin_osel     (pin_osel),
  .wd_reload    (wd_reload),
  .wd_use_safe  (wd_use_safe),
  .wd_safe_code (wd_safe_code),
  .active_code  (active_code),
  .code_update  (code_update),
  .sw_sel_en    (sw_sel_en),
  .mn_active    (mn_active),
  .fs_readback  (fs_readback),
  .drv_readback (drv_readback),
  .osel         (osel),
  .strap_frozen (strap_frozen)
);

// File: tb/strap_freq_select_tb_top.sv
module strap_freq_select_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwrgd_n;
  logic [4:0] pin_fs;
  logic [1:0] pin_drv;
  logic [1:0] pin_osel;
  logic       osel_we;
  logic [1:0] osel_wdata;
  logic       sel_we;
  logic       sel_en_wdata;
  logic [4:0] sel_code_wdata;
  logic       mn_we;
  logic       mn_en_wdata;
  logic [4:0] m_wdata;
  logic [8:0] n_wdata;
  logic       wd_reload;
  logic       wd_use_safe;
  logic [4:0] wd_safe_code;
  logic [4:0] active_code;
  logic       code_update;
  logic       sw_sel_en;
  logic [4:0] sw_code;
  logic       mn_active;
  logic [4:0] m_div;
  logic [8:0] n_div;
  logic [4:0] fs_readback;
  logic [1:0] drv_readback;
  logic [1:0] osel;
  logic       strap_frozen;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  strap_freq_select dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    osel_we = 0; sel_we = 0; mn_we = 0; wd_reload = 0;
  endtask

  function automatic logic [4:0] exp_active(input logic en, input logic [4:0] code,
                                            input logic [4:0] fs);
    return en ? code : fs;
  endfunction

  task automatic do_reset();
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic       m_en, m_mn;
    logic [4:0] m_code, old_act, new_act;
    void'($urandom(32'd4242));
    pwrgd_n = 1; pin_fs = 5'h13; pin_drv = 2'b10; pin_osel = 2'b11;
    osel_wdata = 0; sel_en_wdata = 0; sel_code_wdata = 0; mn_en_wdata = 0;
    m_wdata = 0; n_wdata = 0; wd_use_safe = 0; wd_safe_code = 0;
    idle();
    do_reset();

    // Reset state (strobe still high, nothing sampled)
    chk("R1 active", active_code, 0);
    chk("R1 fs_readback", fs_readback, 0);
    chk("R1 drv", drv_readback, 0);
    chk("R1 osel", osel, 0);
    chk("R1 sw_en", sw_sel_en, 0);
    chk("R1 mn", mn_active, 0);
    chk("R1 m_div", m_div, 5'b01101);
    chk("R1 n_div", n_div, 9'h167);
    chk("R1 update", code_update, 0);
    chk("R1 frozen", strap_frozen, 0);

    // Strobe low: pins sampled
    pwrgd_n = 0;
    tick();
    chk("R2 fs sampled", fs_readback, 5'h13);
    chk("R12 drv sampled", drv_readback, 2'b10);
    chk("R4 osel from pins", osel, 2'b11);
    chk("R5 active from pins", active_code, 5'h13);
    chk("R11 update high", code_update, 1);
    tick();
    chk("R11 update one cycle", code_update, 0);

    // Pins move while strobe low; pre-freeze software osel write ignored
    pin_fs = 5'h05; osel_we = 1; osel_wdata = 2'b00;
    tick(); idle();
    chk("R2 fs resampled", fs_readback, 5'h05);
    chk("R4 pre-freeze write ignored", osel, 2'b11);

    // Strobe returns high: freeze
    pwrgd_n = 1;
    tick();
    chk("R3 frozen", strap_frozen, 1);
    pin_fs = 5'h1F; pin_drv = 2'b00; pin_osel = 2'b00; pwrgd_n = 0;
    repeat (3) tick();
    pwrgd_n = 1;
    repeat (2) tick();
    chk("R3 fs held", fs_readback, 5'h05);
    chk("R12 drv held", drv_readback, 2'b10);
    chk("R3 osel held", osel, 2'b11);
    chk("R3 active held", active_code, 5'h05);

    // Software owns osel after freeze
    osel_we = 1; osel_wdata = 2'b01;
    tick(); idle();
    chk("R4 post-freeze write", osel, 2'b01);

    // Software source
    sel_we = 1; sel_en_wdata = 1; sel_code_wdata = 5'h1A;
    tick(); idle();
    chk("R5 sw active", active_code, 5'h1A);
    chk("R6 readback unchanged", fs_readback, 5'h05);
    chk("R11 update on sw", code_update, 1);

    // Divider programming
    mn_we = 1; mn_en_wdata = 1; m_wdata = 5'd3; n_wdata = 9'h0AB;
    tick(); idle();
    chk("R10 mn en", mn_active, 1);
    chk("R10 m", m_div, 5'd3);
    chk("R10 n", n_div, 9'h0AB);

    // Safe reload colliding with software writes
    wd_reload = 1; wd_use_safe = 1; wd_safe_code = 5'h0E;
    sel_we = 1; sel_en_wdata = 0; sel_code_wdata = 5'h01;
    mn_we = 1; mn_en_wdata = 1; m_wdata = 5'd9; n_wdata = 9'h1FF;
    tick(); idle();
    chk("R7 active safe", active_code, 5'h0E);
    chk("R7 sw_en set", sw_sel_en, 1);
    chk("R9 mn cleared", mn_active, 0);
    chk("R9 m kept", m_div, 5'd3);
    chk("R9 n kept", n_div, 9'h0AB);

    // Pin-code reload
    wd_reload = 1; wd_use_safe = 0;
    tick(); idle();
    chk("R8 sw_en clear", sw_sel_en, 0);
    chk("R8 active pins", active_code, 5'h05);
    chk("R8 sw_code pins", sw_code, 5'h05);

    // Random phase with a bench model
    m_en = 0; m_code = 5'h05; m_mn = 0;
    for (int i = 0; i < 400; i++) begin
      sel_we = ($urandom % 4) == 0;
      sel_en_wdata = 1'($urandom);
      sel_code_wdata = 5'($urandom);
      mn_we = ($urandom % 5) == 0;
      mn_en_wdata = 1'($urandom);
      m_wdata = 5'($urandom);
      n_wdata = 9'($urandom);
      wd_reload = ($urandom % 8) == 0;
      wd_use_safe = 1'($urandom);
      wd_safe_code = 5'($urandom);
      old_act = exp_active(m_en, m_code, 5'h05);
      if (wd_reload) begin
        m_en = wd_use_safe; m_code = wd_use_safe ? wd_safe_code : 5'h05; m_mn = 0;
      end else begin
        if (sel_we) begin m_en = sel_en_wdata; m_code = sel_code_wdata; end
        if (mn_we) m_mn = mn_en_wdata;
      end
      new_act = exp_active(m_en, m_code, 5'h05);
      tick(); idle();
      chk("R5 rnd active", active_code, new_act);
      chk("R7 rnd sw_en", sw_sel_en, m_en);
      chk("R9 rnd mn", mn_active, m_mn);
      chk("R11 rnd update", code_update, old_act != new_act);
      chk("R6 rnd readback", fs_readback, 5'h05);
    end

    // New reset re-opens the capture window
    pin_fs = 5'h09; pin_drv = 2'b01; pwrgd_n = 0;
    do_reset();
    chk("R3 recapture after reset", fs_readback, 5'h09);
    chk("R12 drv after reset", drv_readback, 2'b01);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule